// File: doc/BRIEF.md
# Atomic Compare-and-Swap Sequencer

This unit carries out one indivisible compare-and-swap on a memory word reached over a plain read/write bus that has a lock line. A request gives an operand size (byte, halfword or word), a word address, an accumulator value and a replacement value. The unit reads the word under lock. It compares the selected low part of the accumulator with the same part of the word, then writes the word back under the same lock. The write carries the replacement on a match and the unmodified old word on a mismatch. It then pulses `done` with the comparison flags and the updated accumulator.

The bus works on whole words. A narrow operand therefore becomes a read-modify-write of the full word, in which only the low byte or halfword lanes can change. The controller moves through five named states. IDLE goes to LOCK_RD when a request is accepted. LOCK_RD goes to EVAL when the read is acknowledged. EVAL always goes to LOCK_WR after one cycle. LOCK_WR goes to FINISH when the write is acknowledged. FINISH always returns to IDLE after one cycle.

Top module: `cas_unit`

## Requirements
- R1: `req_size` picks the operand width: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 and 2'b11 = 32 bits. The compare and all flags use only the low bits of that width of the accumulator and of the memory word.
- R2: A request is taken only while `req_ready` is high, which is only in IDLE. In the cycle after it is taken, `bus_rd` and `bus_lock` are high, `bus_addr` equals the request address, and `req_ready` is low.
- R3: On a match, `res_zf` is 1 and `res_acc` equals the request accumulator. The word written back has its selected low bits taken from the replacement value and its remaining bits taken from the old word.
- R4: On a mismatch, `res_zf` is 0 and the old word is written back unchanged, so memory does not change. `res_acc` has its selected low bits taken from the old word and its upper bits taken from the request accumulator.
- R5: Every acknowledged locked read is followed by exactly one acknowledged write to the same address. `bus_lock` stays high from the read request until the write acknowledge and is low in IDLE and FINISH.
- R6: `res_cf` is the borrow of accumulator minus memory at the selected width. `res_sf` is the top bit of that difference. `res_of` is the signed overflow of that subtraction.
- R7: `res_pf` is 1 when the low 8 bits of the difference hold an even number of ones. `res_af` is the borrow out of bit 3.
- R8: `done` is high for exactly one cycle per request. `res_*` are valid in that cycle and stay put until the next comparison.
- R9: After reset the unit is in IDLE: `req_ready` is 1, and `bus_rd`, `bus_wr`, `bus_lock` and `done` are 0.
- R10: A `req_valid` held high while the unit is busy has no effect. No second read occurs and no other address is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_size | input | 2 | Operand width code |
| req_addr | input | ADDR_W | Word address |
| req_acc | input | DATA_W | Accumulator value |
| req_src | input | DATA_W | Replacement value |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write request |
| bus_lock | output | 1 | Bus lock |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with acknowledge |
| bus_ack | input | 1 | Slave acknowledge |
| done | output | 1 | Completion pulse |
| res_zf | output | 1 | Match flag |
| res_cf | output | 1 | Borrow flag |
| res_pf | output | 1 | Parity flag |
| res_af | output | 1 | Nibble borrow flag |
| res_sf | output | 1 | Sign flag |
| res_of | output | 1 | Overflow flag |
| res_acc | output | DATA_W | Updated accumulator |

## Verification
The hardest case to reach is a narrow match in which the memory word differs from the accumulator only above the operand width. A correct design must report a match, leave the upper memory bits alone and keep the whole accumulator. The stimulus builds such words on purpose by flipping only the bits outside the selected lanes, and interleaves these with mismatches whose low byte always differs. A second hard case is a request held on `req_valid` through a whole transaction. Some requests keep a second, different request asserted while the unit is busy, and the bench then confirms that only one read happened and that the other address is untouched.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOCK_RD = 3'd1,
        ST_EVAL    = 3'd2,
        ST_LOCK_WR = 3'd3,
        ST_FINISH  = 3'd4
    } cas_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } cas_size_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic pf;
        logic af;
        logic sf;
        logic of;
    } cas_flags_t;

endpackage

// File: rtl/cas_lane_sel.sv
// Derives per-byte-lane enables and a bit mask from the operand size code.
module cas_lane_sel
    import cas_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [1:0]        size,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (cas_size_e'(size))
                SZ_BYTE: lane_en[g] = (g < 1);
                SZ_HALF: lane_en[g] = (g < 2);
                default: lane_en[g] = 1'b1;
            endcase
        end
        assign mask[8*g +: 8] = {8{lane_en[g]}};
    end
endmodule

// File: rtl/cas_lane_merge.sv
// Builds a word from two sources lane by lane: enabled lanes from ins, others from base.
module cas_lane_merge #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] ins,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_mrg
        assign merged[8*g +: 8] = lane_en[g] ? ins[8*g +: 8] : base[8*g +: 8];
    end
endmodule

// File: rtl/cas_cmp_flags.sv
// Width-aware subtraction of memory from accumulator and the resulting flags.
module cas_cmp_flags
    import cas_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem,
    output cas_flags_t        flags
);
    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W:0]   wide_diff;
    logic [DATA_W-1:0] diff;
    logic [4:0]        nib_diff;
    logic [IDX_W-1:0]  top;
    logic              a_top;
    logic              b_top;
    logic              d_top;

    always_comb begin
        a_m       = acc & mask;
        b_m       = mem & mask;
        wide_diff = {1'b0, a_m} - {1'b0, b_m};
        diff      = wide_diff[DATA_W-1:0];
        nib_diff  = {1'b0, a_m[3:0]} - {1'b0, b_m[3:0]};
        unique case (cas_size_e'(size))
            SZ_BYTE: top = IDX_W'(7);
            SZ_HALF: top = IDX_W'(15);
            default: top = IDX_W'(DATA_W - 1);
        endcase
        a_top = a_m[top];
        b_top = b_m[top];
        d_top = diff[top];

        flags.zf = (a_m == b_m);
        flags.cf = wide_diff[DATA_W];
        flags.pf = ~^diff[7:0];
        flags.af = nib_diff[4];
        flags.sf = d_top;
        flags.of = (a_top != b_top) && (d_top != a_top);
    end
endmodule

// File: rtl/cas_seq.sv
// Controller: IDLE -> LOCK_RD -> EVAL -> LOCK_WR -> FINISH -> IDLE.
module cas_seq
    import cas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_ack,
    output logic req_ready,
    output logic bus_rd,
    output logic bus_wr,
    output logic bus_lock,
    output logic done,
    output logic take_req,
    output logic take_rd,
    output logic take_eval
);
    cas_state_e state_q;
    cas_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOCK_RD;
            ST_LOCK_RD: if (bus_ack)   state_d = ST_EVAL;
            ST_EVAL:                   state_d = ST_LOCK_WR;
            ST_LOCK_WR: if (bus_ack)   state_d = ST_FINISH;
            ST_FINISH:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_lock  = 1'b0;
        done      = 1'b0;
        take_req  = 1'b0;
        take_rd   = 1'b0;
        take_eval = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                take_req  = req_valid;
            end
            ST_LOCK_RD: begin
                bus_rd   = 1'b1;
                bus_lock = 1'b1;
                take_rd  = bus_ack;
            end
            ST_EVAL: begin
                bus_lock  = 1'b1;
                take_eval = 1'b1;
            end
            ST_LOCK_WR: begin
                bus_wr   = 1'b1;
                bus_lock = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_rd && bus_lock && !req_ready));

    // R5
    read_then_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ack) |=> (bus_lock && !bus_rd));

    // R5
    unlock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> $past(bus_wr && bus_ack));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/cas_unit.sv
module cas_unit
    import cas_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_acc,
    input  logic [DATA_W-1:0] req_src,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic              res_zf,
    output logic              res_cf,
    output logic              res_pf,
    output logic              res_af,
    output logic              res_sf,
    output logic              res_of,
    output logic [DATA_W-1:0] res_acc
);
    logic take_req;
    logic take_rd;
    logic take_eval;

    logic [1:0]        size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] racc_q;
    cas_flags_t        flags_q;

    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] mask;
    cas_flags_t        flags_d;
    logic [DATA_W-1:0] swap_word;
    logic [DATA_W-1:0] miss_acc;

    cas_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ack   (bus_ack),
        .req_ready (req_ready),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_lock  (bus_lock),
        .done      (done),
        .take_req  (take_req),
        .take_rd   (take_rd),
        .take_eval (take_eval)
    );

    cas_lane_sel #(.DATA_W(DATA_W)) u_lanes (
        .size    (size_q),
        .lane_en (lane_en),
        .mask    (mask)
    );

    cas_cmp_flags #(.DATA_W(DATA_W)) u_cmp (
        .size  (size_q),
        .mask  (mask),
        .acc   (acc_q),
        .mem   (old_q),
        .flags (flags_d)
    );

    cas_lane_merge #(.DATA_W(DATA_W)) u_swap (
        .lane_en (lane_en),
        .base    (old_q),
        .ins     (src_q),
        .merged  (swap_word)
    );

    cas_lane_merge #(.DATA_W(DATA_W)) u_accm (
        .lane_en (lane_en),
        .base    (acc_q),
        .ins     (old_q),
        .merged  (miss_acc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= '0;
            addr_q  <= '0;
            acc_q   <= '0;
            src_q   <= '0;
            old_q   <= '0;
            wdata_q <= '0;
            racc_q  <= '0;
            flags_q <= '0;
        end else begin
            if (take_req) begin
                size_q <= req_size;
                addr_q <= req_addr;
                acc_q  <= req_acc;
                src_q  <= req_src;
            end
            if (take_rd) begin
                old_q <= bus_rdata;
            end
            if (take_eval) begin
                flags_q <= flags_d;
                wdata_q <= flags_d.zf ? swap_word : old_q;
                racc_q  <= flags_d.zf ? acc_q : miss_acc;
            end
        end
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign res_acc   = racc_q;
    assign res_zf    = flags_q.zf;
    assign res_cf    = flags_q.cf;
    assign res_pf    = flags_q.pf;
    assign res_af    = flags_q.af;
    assign res_sf    = flags_q.sf;
    assign res_of    = flags_q.of;

    // R6
    match_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_zf) |-> (!res_cf && !res_sf && !res_of && !res_af && res_pf));

    // R5
    write_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |-> ($stable(bus_wdata) && $stable(bus_addr)));

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_wr && bus_ack));
endmodule

// File: tb/sim_cas_unit.sv
module sim_cas_unit;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_acc = '0;
    logic [DW-1:0] req_src = '0;
    logic          bus_rd, bus_wr, bus_lock;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic          done;
    logic          res_zf, res_cf, res_pf, res_af, res_sf, res_of;
    logic [DW-1:0] res_acc;

    always #10 clk = ~clk;

    cas_unit #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_addr(req_addr), .req_acc(req_acc), .req_src(req_src),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_lock(bus_lock), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done),
        .res_zf(res_zf), .res_cf(res_cf), .res_pf(res_pf), .res_af(res_af),
        .res_sf(res_sf), .res_of(res_of), .res_acc(res_acc)
    );

    // simple synchronous slave, acknowledges one cycle after a request
    logic [DW-1:0] mem [16];
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
        end else begin
            bus_ack <= (bus_rd || bus_wr) && !bus_ack;
            if (bus_rd && !bus_ack) bus_rdata <= mem[bus_addr[3:0]];
            if (bus_wr && !bus_ack) mem[bus_addr[3:0]] = bus_wdata;
        end
    end

    // bus monitor
    int          n_rd, n_wr, n_badaddr, n_gap;
    logic [AW-1:0] rd_addr_seen;
    always @(negedge clk) begin
        if (rst_n) begin
            if (n_rd > n_wr && !bus_lock) n_gap++;
            if (bus_rd && bus_ack) begin
                n_rd++;
                rd_addr_seen = bus_addr;
            end
            if (bus_wr && bus_ack) begin
                n_wr++;
                if (bus_addr != rd_addr_seen) n_badaddr++;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    endfunction

    task automatic run_cas(input logic [1:0] sz, input logic [3:0] ad, input logic [DW-1:0] acc,
                           input logic [DW-1:0] src, input logic [DW-1:0] mval, input bit busy);
        int          w;
        longint      modv, a, b, s, d, sa, sb, sd, ones, lowmask;
        logic [DW-1:0] exp_mem, exp_acc, other_before;
        logic        e_zf, e_cf, e_pf, e_af, e_sf, e_of;
        w       = width_of(sz);
        modv    = longint'(1) << w;
        lowmask = modv - 1;
        a  = longint'(acc) % modv;
        b  = longint'(mval) % modv;
        s  = longint'(src) % modv;
        d  = (a - b + modv) % modv;
        sa = (a >= modv / 2) ? a - modv : a;
        sb = (b >= modv / 2) ? b - modv : b;
        sd = sa - sb;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (d >> i) & 1;
        e_zf = (a == b);
        e_cf = (a < b);
        e_sf = ((d >> (w - 1)) & 1) != 0;
        e_of = (sd < -(modv / 2)) || (sd >= modv / 2);
        e_pf = (ones % 2) == 0;
        e_af = (a % 16) < (b % 16);
        if (e_zf) begin
            exp_mem = DW'((longint'(mval) - b) + s);
            exp_acc = acc;
        end else begin
            exp_mem = mval;
            exp_acc = DW'((longint'(acc) - a) + b);
        end

        mem[ad] = mval;
        other_before = mem[ad ^ 4'd1];
        n_rd = 0; n_wr = 0; n_badaddr = 0; n_gap = 0;
        req_size = sz; req_addr = AW'(ad); req_acc = acc; req_src = src; req_valid = 1'b1;
        @(negedge clk);
        // R2: read issued under lock to request address
        chk("R2 rd", {31'd0, bus_rd}, 32'd1);
        chk("R2 lock", {31'd0, bus_lock}, 32'd1);
        chk("R2 addr", {24'd0, bus_addr}, {28'd0, ad});
        chk("R2 ready low", {31'd0, req_ready}, 32'd0);
        if (busy) begin
            req_addr = AW'(ad ^ 4'd1); req_acc = ~acc; req_src = ~src;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        // R1 R3 R4
        chk(e_zf ? "R3 zf" : "R4 zf", {31'd0, res_zf}, {31'd0, e_zf});
        chk(e_zf ? "R3 acc" : "R4 acc", res_acc, exp_acc);
        chk(e_zf ? "R3 mem" : "R4 mem unchanged", mem[ad], exp_mem);
        // R6
        chk("R6 cf", {31'd0, res_cf}, {31'd0, e_cf});
        chk("R6 sf", {31'd0, res_sf}, {31'd0, e_sf});
        chk("R6 of", {31'd0, res_of}, {31'd0, e_of});
        // R7
        chk("R7 pf", {31'd0, res_pf}, {31'd0, e_pf});
        chk("R7 af", {31'd0, res_af}, {31'd0, e_af});
        // R5
        chk("R5 reads", 32'(n_rd), 32'd1);
        chk("R5 writes", 32'(n_wr), 32'd1);
        chk("R5 same addr", 32'(n_badaddr), 32'd0);
        chk("R5 lock gap", 32'(n_gap), 32'd0);
        if (busy) chk("R10 other addr", mem[ad ^ 4'd1], other_before);
        @(negedge clk);
        // R8: single-cycle pulse, results held
        chk("R8 done low", {31'd0, done}, 32'd0);
        chk("R8 acc held", res_acc, exp_acc);
        chk("R5 unlocked", {31'd0, bus_lock}, 32'd0);
        chk("R2 ready", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 * i + 32'h0011_2233;
        repeat (3) @(negedge clk);
        // R9
        chk("R9 ready", {31'd0, req_ready}, 32'd1);
        chk("R9 rd", {31'd0, bus_rd}, 32'd0);
        chk("R9 wr", {31'd0, bus_wr}, 32'd0);
        chk("R9 lock", {31'd0, bus_lock}, 32'd0);
        chk("R9 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // byte sweep over nibble patterns (R1 R6 R7)
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [DW-1:0] av, bv;
                av = 32'hC3C3_C300 | 32'(i * 17);
                bv = (i == j) ? (32'h5A5A_5A00 | 32'(i * 17))
                              : (32'h5A5A_5A00 | 32'(j * 16 + (15 - j)));
                run_cas(2'b00, 4'(i), av, 32'h0000_00E7 ^ 32'(j), bv, 1'b0);
            end
        end

        // interleaved match / mismatch at every size code
        for (int k = 0; k < 48; k++) begin
            logic [1:0]    sz;
            logic [DW-1:0] av, mv, upper;
            sz = 2'(k % 4);
            av = 32'(k) * 32'h9E37_79B1 ^ 32'h8000_8080;
            upper = (sz == 2'b00) ? 32'h5A5A_5A00 : (sz == 2'b01) ? 32'h5A5A_0000 : 32'h0;
            if ((k / 4) % 2 == 0) mv = av ^ upper;
            else                  mv = av + 32'(k) * 32'h0101_0101 + 32'd1;
            run_cas(sz, 4'(k % 16), av, 32'hF00D_0000 + 32'(k * 7919), mv, (k % 3) == 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule